// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The unit counts hardware activity for profiling. It holds one free-running cycle counter and four event counters, each 32 bits wide, behind a small register port. Software first picks an event counter through a select register. It then sets that counter's event code and initial value through two indirect registers and turns counters on with separate set and clear enable registers. The run starts and stops with the global enable bit in the control register. Each event counter watches one of `NUM_EVT` single-cycle event pulse inputs. The cycle counter advances on every clock, or once every 64 clocks when the prescale bit is set.

Register index map: 0 control, 1 enable-set, 2 enable-clear, 3 counter select, 4 event select (indirect), 5 event counter value (indirect), 6 cycle counter, 7 reserved (reads zero). A write takes effect at the clock edge where `reg_we_i` is high. Reads are combinational from `reg_idx_i`.

Top module: `pmu_core`

## Requirements
- R1: After reset every register index reads zero.
- R2: Control bits 0 (global enable), 3 (cycle prescale by 64), 4 and 5 (stored only) hold the written value. Bits 1 and 2 and bits 31:6 always read zero.
- R3: In both enable registers, bit 31 stands for the cycle counter and bit i (i = 0..3) for event counter i. A one written to the set register turns that counter on, and a one written to the clear register turns it off. Zero bits change nothing. Both indices read back the current enable mask.
- R4: A counter advances only while control bit 0 and its own enable bit are both set. Otherwise it holds its value.
- R5: An event counter whose event code c is below `NUM_EVT` adds one for each enabled clock in which `evt_i[c]` is high. A code of `NUM_EVT` or above leaves it idle.
- R6: With control bit 3 clear, the cycle counter adds one per enabled clock. With bit 3 set, it adds one on every 64th enabled clock, counted by a prescaler that keeps its phase across disables.
- R7: A write to a value register (index 5 for the selected event counter, index 6 for the cycle counter) loads the written value. Counters wrap from 0xFFFFFFFF to 0.
- R8: Writing 1 to control bit 1 zeroes all event counters, and writing 1 to bit 2 zeroes the cycle counter and its prescaler. Both act in the same edge as the write and win over counting at that edge.
- R9: Indices 4 and 5 reach the event counter named by the select register (index 3, read back as written). For a select value of 4 or more, these reads return zero and these writes change no counter and no event code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_idx_i | input | 3 | Register index |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_idx_i` |
| evt_i | input | NUM_EVT | Per-cycle event pulses |

## Verification
The bench sweeps every event counter against every valid event code and two out-of-range codes under changing pulse patterns. A wrong input mux or a missing idle case shows as a count mismatch. It brackets the prescaler at 63, 64 and 200 enabled clocks, so a prescaler that loses its phase, or one that is not cleared by the cycle reset bit, gives an off-by-one count. The reset bits are fired while counting is live, which catches a design that lets the increment win over the clear. An out-of-range select is used for both a read and a write, and all counters are read back afterwards, which exposes an index that aliases onto a real counter.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_AW  = 3;
  localparam int DATA_W  = 32;
  localparam int EVSEL_W = 8;
  localparam int PRE_W   = 6;
  localparam int CYC_BIT = 31;

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL  = 3'd0,
    REG_ENSET = 3'd1,
    REG_ENCLR = 3'd2,
    REG_SEL   = 3'd3,
    REG_EVSEL = 3'd4,
    REG_EVAL  = 3'd5,
    REG_CYC   = 3'd6,
    REG_RSVD  = 3'd7
  } reg_idx_e;

  localparam int CTL_EN      = 0;
  localparam int CTL_CLR_EVT = 1;
  localparam int CTL_CLR_CYC = 2;
  localparam int CTL_DIV     = 3;
  localparam int CTL_EXP     = 4;
  localparam int CTL_DBG     = 5;
  localparam int CTL_W       = 6;
endpackage

// File: rtl/pmu_regs.sv
module pmu_regs #(
  parameter int NUM_CNT = 4,
  parameter int SEL_W   = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_ctrl_i,
  input  logic                     we_enset_i,
  input  logic                     we_enclr_i,
  input  logic                     we_sel_i,
  input  logic [pmu_pkg::CTL_W-1:0] ctrl_wd_i,
  input  logic [NUM_CNT:0]         en_wd_i,   // [NUM_CNT] = cycle counter
  input  logic [SEL_W-1:0]         sel_wd_i,
  output logic                     glob_en_o,
  output logic                     div_o,
  output logic                     exp_o,
  output logic                     dbg_o,
  output logic                     clr_evt_o,
  output logic                     clr_cyc_o,
  output logic [NUM_CNT-1:0]       evt_en_o,
  output logic                     cyc_en_o,
  output logic [SEL_W-1:0]         sel_o
);
  import pmu_pkg::*;

  logic             en_q, div_q, exp_q, dbg_q;
  logic [NUM_CNT:0] cnt_en_q;
  logic [SEL_W-1:0] sel_q;
  logic [NUM_CNT:0] set_m, clr_m;

  assign set_m = we_enset_i ? en_wd_i : '0;
  assign clr_m = we_enclr_i ? en_wd_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      div_q    <= 1'b0;
      exp_q    <= 1'b0;
      dbg_q    <= 1'b0;
      cnt_en_q <= '0;
      sel_q    <= '0;
    end else begin
      if (we_ctrl_i) begin
        en_q  <= ctrl_wd_i[CTL_EN];
        div_q <= ctrl_wd_i[CTL_DIV];
        exp_q <= ctrl_wd_i[CTL_EXP];
        dbg_q <= ctrl_wd_i[CTL_DBG];
      end
      cnt_en_q <= (cnt_en_q | set_m) & ~clr_m;
      if (we_sel_i) sel_q <= sel_wd_i;
    end
  end

  // reset bits are pulses: never stored
  assign clr_evt_o = we_ctrl_i & ctrl_wd_i[CTL_CLR_EVT];
  assign clr_cyc_o = we_ctrl_i & ctrl_wd_i[CTL_CLR_CYC];
  assign glob_en_o = en_q;
  assign div_o     = div_q;
  assign exp_o     = exp_q;
  assign dbg_o     = dbg_q;
  assign evt_en_o  = cnt_en_q[NUM_CNT-1:0];
  assign cyc_en_o  = cnt_en_q[NUM_CNT];
  assign sel_o     = sel_q;
endmodule

// File: rtl/pmu_evt_cnt.sv
module pmu_evt_cnt #(
  parameter int NUM_EVT = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        ld_i,
  input  logic [pmu_pkg::DATA_W-1:0]  ld_val_i,
  input  logic                        code_we_i,
  input  logic [pmu_pkg::EVSEL_W-1:0] code_i,
  input  logic                        cnt_en_i,
  input  logic [NUM_EVT-1:0]          evt_i,
  output logic [pmu_pkg::DATA_W-1:0]  cnt_o,
  output logic [pmu_pkg::EVSEL_W-1:0] code_o
);
  import pmu_pkg::*;

  logic [EVSEL_W-1:0] code_q;
  logic [DATA_W-1:0]  cnt_q;
  logic               hit;

  always_comb begin
    hit = 1'b0;
    for (int e = 0; e < NUM_EVT; e++)
      if (int'(code_q) == e) hit = evt_i[e];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (code_we_i) code_q <= code_i;
      if (clr_i)                cnt_q <= '0;
      else if (ld_i)            cnt_q <= ld_val_i;
      else if (cnt_en_i && hit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign code_o = code_q;
endmodule

// File: rtl/pmu_cyc_cnt.sv
module pmu_cyc_cnt #(
  parameter int PRE_W = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       ld_i,
  input  logic [pmu_pkg::DATA_W-1:0] ld_val_i,
  input  logic                       cnt_en_i,
  input  logic                       div_i,
  output logic [pmu_pkg::DATA_W-1:0] cnt_o
);
  import pmu_pkg::*;

  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] cnt_q;
  logic              tick;

  assign tick = div_i ? (&pre_q) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cnt_en_i && div_i) pre_q <= pre_q + 1'b1;
      if (ld_i)                  cnt_q <= ld_val_i;
      else if (cnt_en_i && tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_core.sv
module pmu_core #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [pmu_pkg::REG_AW-1:0]  reg_idx_i,
  input  logic                        reg_we_i,
  input  logic [pmu_pkg::DATA_W-1:0]  reg_wdata_i,
  output logic [pmu_pkg::DATA_W-1:0]  reg_rdata_o,
  input  logic [NUM_EVT-1:0]          evt_i
);
  import pmu_pkg::*;

  localparam int SEL_IW = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int SEL_W  = SEL_IW + 1;

  logic               glob_en, div, exp_b, dbg_b, clr_evt, clr_cyc, cyc_en_q;
  logic [NUM_CNT-1:0] evt_en;
  logic [SEL_W-1:0]   sel_q;
  logic               sel_ok;
  logic [DATA_W-1:0]  cyc_cnt;
  logic [DATA_W-1:0]  evt_cnt [NUM_CNT];
  logic [EVSEL_W-1:0] evt_code[NUM_CNT];
  logic [DATA_W-1:0]  en_rd;

  assign sel_ok = int'(sel_q) < NUM_CNT;

  pmu_regs #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_ctrl_i  (reg_we_i && reg_idx_i == REG_CTRL),
    .we_enset_i (reg_we_i && reg_idx_i == REG_ENSET),
    .we_enclr_i (reg_we_i && reg_idx_i == REG_ENCLR),
    .we_sel_i   (reg_we_i && reg_idx_i == REG_SEL),
    .ctrl_wd_i  (reg_wdata_i[CTL_W-1:0]),
    .en_wd_i    ({reg_wdata_i[CYC_BIT], reg_wdata_i[NUM_CNT-1:0]}),
    .sel_wd_i   (reg_wdata_i[SEL_W-1:0]),
    .glob_en_o  (glob_en),
    .div_o      (div),
    .exp_o      (exp_b),
    .dbg_o      (dbg_b),
    .clr_evt_o  (clr_evt),
    .clr_cyc_o  (clr_cyc),
    .evt_en_o   (evt_en),
    .cyc_en_o   (cyc_en_q),
    .sel_o      (sel_q)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q[SEL_IW-1:0] == SEL_IW'(i));
    pmu_evt_cnt #(.NUM_EVT(NUM_EVT)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_i     (clr_evt),
      .ld_i      (reg_we_i && reg_idx_i == REG_EVAL && hit_sel),
      .ld_val_i  (reg_wdata_i),
      .code_we_i (reg_we_i && reg_idx_i == REG_EVSEL && hit_sel),
      .code_i    (reg_wdata_i[EVSEL_W-1:0]),
      .cnt_en_i  (glob_en && evt_en[i]),
      .evt_i     (evt_i),
      .cnt_o     (evt_cnt[i]),
      .code_o    (evt_code[i])
    );
  end

  pmu_cyc_cnt #(.PRE_W(PRE_W)) u_cyc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_cyc),
    .ld_i     (reg_we_i && reg_idx_i == REG_CYC),
    .ld_val_i (reg_wdata_i),
    .cnt_en_i (glob_en && cyc_en_q),
    .div_i    (div),
    .cnt_o    (cyc_cnt)
  );

  always_comb begin
    en_rd                 = '0;
    en_rd[CYC_BIT]        = cyc_en_q;
    en_rd[NUM_CNT-1:0]    = evt_en;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_idx_i)
      REG_CTRL: begin
        reg_rdata_o[CTL_EN]  = glob_en;
        reg_rdata_o[CTL_DIV] = div;
        reg_rdata_o[CTL_EXP] = exp_b;
        reg_rdata_o[CTL_DBG] = dbg_b;
      end
      REG_ENSET, REG_ENCLR: reg_rdata_o = en_rd;
      REG_SEL:   reg_rdata_o = DATA_W'(sel_q);
      REG_EVSEL: if (sel_ok) reg_rdata_o = DATA_W'(evt_code[sel_q[SEL_IW-1:0]]);
      REG_EVAL:  if (sel_ok) reg_rdata_o = evt_cnt[sel_q[SEL_IW-1:0]];
      REG_CYC:   reg_rdata_o = cyc_cnt;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pmu_core_chk.sv
module pmu_core_chk #(
  parameter int NUM_CNT = 4,
  parameter int SEL_W   = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [pmu_pkg::REG_AW-1:0] reg_idx_i,
  input logic                       reg_we_i,
  input logic [pmu_pkg::DATA_W-1:0] reg_wdata_i,
  input logic [pmu_pkg::DATA_W-1:0] reg_rdata_o,
  input logic                       glob_en,
  input logic                       cyc_en,
  input logic [SEL_W-1:0]           sel_q,
  input logic [pmu_pkg::DATA_W-1:0] cyc_cnt,
  input logic [pmu_pkg::DATA_W-1:0] cnt0,
  input logic [pmu_pkg::DATA_W-1:0] cnt_last
);
  import pmu_pkg::*;

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_idx_i == REG_CTRL |-> (reg_rdata_o[31:6] == '0 && reg_rdata_o[2:1] == 2'b00)); // R2

  AST_ENSET_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == REG_ENSET && reg_wdata_i[CYC_BIT]) |=> cyc_en); // R3

  AST_ENCLR_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == REG_ENCLR && reg_wdata_i[CYC_BIT]) |=> !cyc_en); // R3

  AST_CYC_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!glob_en && !reg_we_i) |=> $stable(cyc_cnt)); // R4

  AST_EVT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 32'd1)); // R5

  AST_CLR_EVT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == REG_CTRL && reg_wdata_i[CTL_CLR_EVT]) |=> (cnt0 == '0 && cnt_last == '0)); // R8

  AST_CLR_CYC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_idx_i == REG_CTRL && reg_wdata_i[CTL_CLR_CYC]) |=> cyc_cnt == '0); // R8

  AST_SEL_OOR_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_q) >= NUM_CNT && (reg_idx_i == REG_EVAL || reg_idx_i == REG_EVSEL)) |-> reg_rdata_o == '0); // R9
endmodule

bind pmu_core pmu_core_chk #(.NUM_CNT(NUM_CNT), .SEL_W(SEL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_idx_i   (reg_idx_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .glob_en     (glob_en),
  .cyc_en      (cyc_en_q),
  .sel_q       (sel_q),
  .cyc_cnt     (cyc_cnt),
  .cnt0        (evt_cnt[0]),
  .cnt_last    (evt_cnt[NUM_CNT-1])
);

// File: tb/sim_pmu_core.sv
`timescale 1ns/1ps
module sim_pmu_core;
  localparam int NC = 4;
  localparam int NE = 8;
  localparam logic [2:0] I_CTRL = 3'd0, I_SET = 3'd1, I_CLR = 3'd2, I_SEL = 3'd3,
                         I_EVS = 3'd4, I_EVAL = 3'd5, I_CYC = 3'd6, I_RSV = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  idx = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NE-1:0] evt = '0;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  pmu_core #(.NUM_CNT(NC), .NUM_EVT(NE)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_idx_i(idx), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt)
  );

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    idx = i; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    @(negedge clk);
    idx = i;
    #1 d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [2:0] i, input logic [31:0] exp);
    logic [31:0] v;
    rd(i, v);
    chk(req, v, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int exp_c;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 8; r++) rd_chk("R1", 3'(r), 32'h0);

    // R2 control writable bits
    wr(I_CTRL, 32'hFFFF_FFF8);
    rd_chk("R2", I_CTRL, 32'h0000_0038);
    wr(I_CTRL, 32'h0000_0030);
    rd_chk("R2", I_CTRL, 32'h0000_0030);
    wr(I_CTRL, 32'h0);

    // R3 set / clear enables
    wr(I_SET, 32'h8000_000F);
    rd_chk("R3", I_SET, 32'h8000_000F);
    wr(I_CLR, 32'h0000_0002);
    rd_chk("R3", I_CLR, 32'h8000_000D);
    wr(I_SET, 32'h0);
    wr(I_CLR, 32'h0);
    rd_chk("R3", I_SET, 32'h8000_000D);
    wr(I_CLR, 32'h8000_0000);
    rd_chk("R3", I_SET, 32'h0000_000D);
    wr(I_CLR, 32'hFFFF_FFFF);
    rd_chk("R3", I_SET, 32'h0);

    // R5 sweep: every counter x every code plus out-of-range codes
    for (int c = 0; c < NC; c++) begin
      wr(I_SEL, 32'(c));
      for (int k = 0; k < NE + 2; k++) begin
        int cd;
        cd = (k == NE + 1) ? 63 : k;
        wr(I_EVS, 32'(cd));
        wr(I_EVAL, 32'h0);
        wr(I_SET, 32'(1 << c));
        wr(I_CTRL, 32'h1);
        exp_c = 0;
        for (int t = 0; t < 12; t++) begin
          logic [NE-1:0] pat;
          @(negedge clk);
          pat = NE'((t * 29 + cd * 7 + c * 3) ^ (t << 2));
          evt = pat;
          if (cd < NE && pat[cd]) exp_c++;
          @(posedge clk);
        end
        @(negedge clk) evt = '0;
        wr(I_CTRL, 32'h0);
        wr(I_CLR, 32'(1 << c));
        rd_chk("R5", I_EVAL, 32'(exp_c));
      end
    end

    // R4 own enable off, global on
    wr(I_SEL, 32'd2); wr(I_EVS, 32'd0); wr(I_EVAL, 32'h0);
    @(negedge clk) evt = '1;
    wr(I_CTRL, 32'h1);
    repeat (5) @(posedge clk);
    wr(I_CTRL, 32'h0);
    rd_chk("R4", I_EVAL, 32'h0);
    // R4 own enable on, global off
    wr(I_SET, 32'h4);
    repeat (5) @(posedge clk);
    rd_chk("R4", I_EVAL, 32'h0);
    wr(I_CLR, 32'h4);
    @(negedge clk) evt = '0;

    // R7 event counter wrap
    wr(I_SEL, 32'd1); wr(I_EVS, 32'd2); wr(I_EVAL, 32'hFFFF_FFFE);
    wr(I_SET, 32'h2);
    wr(I_CTRL, 32'h1);
    @(negedge clk) evt = 8'h04;
    repeat (3) @(posedge clk);
    @(negedge clk) evt = '0;
    wr(I_CTRL, 32'h0);
    wr(I_CLR, 32'h2);
    rd_chk("R7", I_EVAL, 32'h1);

    // R6 cycle counter, undivided: 9 + 1 enabled edges
    wr(I_CYC, 32'h0);
    wr(I_SET, 32'h8000_0000);
    wr(I_CTRL, 32'h1);
    repeat (9) @(posedge clk);
    wr(I_CTRL, 32'h0);
    rd_chk("R6", I_CYC, 32'd10);
    repeat (4) @(posedge clk);
    rd_chk("R4", I_CYC, 32'd10);

    // R6 prescaled: 63 edges -> 0, 64th -> 1, then 200 -> 3
    wr(I_CTRL, 32'hC);
    wr(I_CTRL, 32'h9);
    repeat (62) @(posedge clk);
    wr(I_CTRL, 32'h8);
    rd_chk("R6", I_CYC, 32'd0);
    wr(I_CTRL, 32'h9);
    wr(I_CTRL, 32'h8);
    rd_chk("R6", I_CYC, 32'd1);
    wr(I_CTRL, 32'hC);
    rd_chk("R8", I_CYC, 32'd0);
    wr(I_CTRL, 32'h9);
    repeat (199) @(posedge clk);
    wr(I_CTRL, 32'h0);
    rd_chk("R6", I_CYC, 32'd3);

    // R7 cycle wrap
    wr(I_CYC, 32'hFFFF_FFFF);
    wr(I_CTRL, 32'h1);
    repeat (1) @(posedge clk);
    wr(I_CTRL, 32'h0);
    rd_chk("R7", I_CYC, 32'd1);

    // R8 reset bits act separately
    for (int c = 0; c < NC; c++) begin
      wr(I_SEL, 32'(c)); wr(I_EVS, 32'(c + 1)); wr(I_EVAL, 32'(100 + c));
    end
    wr(I_CYC, 32'd555);
    wr(I_CTRL, 32'h2);
    rd_chk("R8", I_CYC, 32'd555);
    for (int c = 0; c < NC; c++) begin
      wr(I_SEL, 32'(c));
      rd_chk("R8", I_EVAL, 32'h0);
      wr(I_EVAL, 32'(10 * c + 7));
    end
    wr(I_CTRL, 32'h4);
    rd_chk("R8", I_CYC, 32'h0);
    wr(I_SEL, 32'd3);
    rd_chk("R8", I_EVAL, 32'd37);

    // R8 priority over live counting
    wr(I_SEL, 32'd0); wr(I_EVS, 32'd0);
    wr(I_SET, 32'h8000_000F);
    @(negedge clk) evt = '1;
    wr(I_CTRL, 32'h1);
    repeat (3) @(posedge clk);
    wr(I_CTRL, 32'h7);
    rd_chk("R8", I_CYC, 32'h0);
    wr(I_CTRL, 32'h3);
    rd_chk("R8", I_EVAL, 32'h0);
    wr(I_CTRL, 32'h0);
    @(negedge clk) evt = '0;
    wr(I_CLR, 32'hFFFF_FFFF);

    // R9 out-of-range select
    wr(I_EVS, 32'd1);
    for (int c = 0; c < NC; c++) begin
      wr(I_SEL, 32'(c)); wr(I_EVS, 32'(c + 1)); wr(I_EVAL, 32'(10 * c));
    end
    wr(I_SEL, 32'd5);
    rd_chk("R9", I_SEL, 32'd5);
    rd_chk("R9", I_EVAL, 32'h0);
    rd_chk("R9", I_EVS, 32'h0);
    wr(I_EVAL, 32'h1234);
    wr(I_EVS, 32'h7);
    for (int c = 0; c < NC; c++) begin
      wr(I_SEL, 32'(c));
      rd_chk("R9", I_EVAL, 32'(10 * c));
      rd_chk("R9", I_EVS, 32'(c + 1));
    end
    rd_chk("R1", I_RSV, 32'h0);

    rd(I_CTRL, v);
    chk("R2", v, 32'h0);
    finish_run();
  end
endmodule